// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Interface with Update Sequencer

This block is the host-facing side of a real-time clock. A host reaches it through two addresses. A write to the even address selects one of 128 byte locations. An access to the odd address then reads or writes the selected byte. The low fourteen locations hold the time fields, three alarm fields and four control bytes, A to D. The remaining locations are general storage.

The block does not count time itself. A separate calendar counter holds the running time and presents it on `calTime`. Once a second a tick arrives. The block tells the counter to advance, sets the update-in-progress flag and waits a short window measured on a slow time-base strobe. It then copies the counter's fields into the registers, checks the alarm and posts interrupt flags. When the host writes new time values, the block hands them to the counter through a one-cycle load pulse. A freeze mode holds the register image still so the host can edit it. The new time reaches the counter when the freeze is released.

Top module: `rtc_host_regs`

## Requirements
- R1: A write with `hostSel`=0 stores `hostWdata[6:0]` as the index, ignoring bit 7. A read with `hostSel`=0 returns 0xFF.
- R2: A write with `hostSel`=1 stores the byte at the current index, and a read returns it. Indexes 14 to 127 are plain storage.
- R3: After reset the control bytes read A (index 10)=0x26, B (11)=0x02, C (12)=0x00 and D (13)=0x80, and `irqOut` is low.
- R4: A host write to index 10 changes bits 6:0 only. Bit 7, the update-in-progress flag, is not writable by the host. Host writes to index 12 and index 13 have no effect.
- R5: Writing index 11 with bit 7 (freeze) set stores bit 4 (update-ended enable) as 0 and clears the update-in-progress flag. Writing index 11 with bit 7 clear while freeze was set issues one `calLoad` pulse.
- R6: A host write to a time field while freeze is clear issues a `calLoad` pulse in the next cycle. The time fields are index 0 seconds, 2 minutes, 4 hours, 6 weekday, 7 day of month, 8 month and 9 year. With freeze set, such a write issues no pulse. `calLoadData` and `calTime` pack seconds in [7:0], minutes [15:8], hours [23:16], weekday [31:24], day of month [39:32], month [47:40] and year [55:48].
- R7: A `secTick` while the update sequence is idle and A[6:4]=010 pulses `calAdvance` in the same cycle. It also sets A bit 7 unless freeze is set. On the edge of the UIP_TICKS-th `baseTick` after that, the seven time fields are copied from `calTime` (not while freezed) and A bit 7 is cleared.
- R8: While A[6:4] is not 010, `secTick` is ignored: there is no `calAdvance`, no update flag and no copy.
- R9: When B bit 4 is set, the end of each update sets C bits 7 and 4. `irqOut` follows C bit 7.
- R10: When B bit 5 is set, the end of an update sets C bits 7 and 5 if each of the alarm fields matches. The alarm fields are index 1 seconds, 3 minutes and 5 hours. A field matches if it has bits 7:6 both 1, or if it equals the same field of `calTime`.
- R11: A read of index 12 returns C and then clears C and `irqOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Address bit: 0 index port, 1 data port |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (clears C when reading index 12) |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data (combinational) |
| secTick | input | 1 | One-second tick, one cycle wide |
| baseTick | input | 1 | Slow time-base strobe that times the update window |
| calTime | input | 56 | Current time from the calendar counter |
| calAdvance | output | 1 | Tells the calendar counter to step one second |
| calLoad | output | 1 | One-cycle pulse: load `calLoadData` into the counter |
| calLoadData | output | 56 | Time fields held in the registers |
| irqOut | output | 1 | Interrupt request |

## Verification
The alarm needs three fields to agree with a moving time, and each field can match exactly, match as don't-care or miss. The bench therefore loads a known time through the host port and predicts the time after each advance. It then sweeps all 27 match/don't-care/miss combinations across seconds, minutes and hours, with one update per combination. Freeze-mode behaviour needs an update to run while freeze is held. The bench edits a field during that freeze and confirms two things: the field survives the copy-out, and it reaches the counter only when freeze is released.

// File: rtl/rtc_reg_pkg.sv
package rtc_reg_pkg;
  localparam int IDX_SEC   = 0;
  localparam int IDX_ASEC  = 1;
  localparam int IDX_MIN   = 2;
  localparam int IDX_AMIN  = 3;
  localparam int IDX_HOUR  = 4;
  localparam int IDX_AHOUR = 5;
  localparam int IDX_WDAY  = 6;
  localparam int IDX_MDAY  = 7;
  localparam int IDX_MON   = 8;
  localparam int IDX_YEAR  = 9;
  localparam int IDX_CTLA  = 10;
  localparam int IDX_CTLB  = 11;
  localparam int IDX_CTLC  = 12;
  localparam int IDX_CTLD  = 13;

  localparam int NUM_TIME_FIELDS = 7;

  localparam logic [7:0] RST_CTLA = 8'h26;
  localparam logic [7:0] RST_CTLB = 8'h02;
  localparam logic [7:0] RST_CTLD = 8'h80;

  // strobes from the update sequencer to the register file
  typedef struct packed {
    logic startUpd;
    logic endUpd;
  } upd_strobe_t;
endpackage

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl
  import rtc_reg_pkg::*;
#(
  parameter int UIP_TICKS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        secTick,
  input  logic        baseTick,
  input  logic        oscRun,
  output upd_strobe_t updStb
);
  localparam int CW = (UIP_TICKS > 1) ? $clog2(UIP_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(UIP_TICKS - 1);

  logic          busy;
  logic [CW-1:0] winCnt;

  always_comb begin
    updStb.startUpd = secTick & oscRun & ~busy;
    updStb.endUpd   = busy & baseTick & (winCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      winCnt <= '0;
    end else if (updStb.startUpd) begin
      busy   <= 1'b1;
      winCnt <= '0;
    end else if (updStb.endUpd) begin
      busy   <= 1'b0;
    end else if (busy && baseTick) begin
      winCnt <= winCnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_reg_file.sv
module rtc_reg_file
  import rtc_reg_pkg::*;
#(
  parameter int INDEX_W = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         hostSel,
  input  logic                         hostWr,
  input  logic                         hostRd,
  input  logic [7:0]                   hostWdata,
  output logic [7:0]                   hostRdata,
  input  upd_strobe_t                  updStb,
  input  logic [8*NUM_TIME_FIELDS-1:0] calTime,
  output logic                         calLoad,
  output logic [8*NUM_TIME_FIELDS-1:0] calLoadData,
  output logic [INDEX_W-1:0]           curIndex,
  output logic                         oscRun,
  output logic                         uipFlag,
  output logic                         uieFlag,
  output logic                         irq
);
  localparam int DEPTH = 1 << INDEX_W;
  localparam logic [INDEX_W-1:0] AI = INDEX_W'(IDX_CTLA);
  localparam logic [INDEX_W-1:0] BI = INDEX_W'(IDX_CTLB);
  localparam logic [INDEX_W-1:0] CI = INDEX_W'(IDX_CTLC);
  localparam logic [INDEX_W-1:0] DI = INDEX_W'(IDX_CTLD);

  logic [7:0]         mem [DEPTH];
  logic [INDEX_W-1:0] idx;
  logic [7:0]         cNext;
  logic               alarmHit;

  function automatic logic [INDEX_W-1:0] timeSlot(input int k);
    case (k)
      0: timeSlot = INDEX_W'(IDX_SEC);
      1: timeSlot = INDEX_W'(IDX_MIN);
      2: timeSlot = INDEX_W'(IDX_HOUR);
      3: timeSlot = INDEX_W'(IDX_WDAY);
      4: timeSlot = INDEX_W'(IDX_MDAY);
      5: timeSlot = INDEX_W'(IDX_MON);
      default: timeSlot = INDEX_W'(IDX_YEAR);
    endcase
  endfunction

  function automatic logic isTimeSlot(input logic [INDEX_W-1:0] i);
    isTimeSlot = 1'b0;
    for (int k = 0; k < NUM_TIME_FIELDS; k++)
      if (i == timeSlot(k)) isTimeSlot = 1'b1;
  endfunction

  function automatic logic fieldHit(input logic [7:0] alarm, input logic [7:0] now);
    fieldHit = (alarm[7:6] == 2'b11) || (alarm == now);
  endfunction

  wire dataWr  = hostWr & hostSel;
  wire dataRd  = hostRd & hostSel;
  wire setMode = mem[BI][7];

  assign curIndex  = idx;
  assign hostRdata = hostSel ? mem[idx] : 8'hFF;
  assign oscRun    = (mem[AI][6:4] == 3'b010);
  assign uipFlag   = mem[AI][7];
  assign uieFlag   = mem[BI][4];
  assign irq       = mem[CI][7];

  assign alarmHit = fieldHit(mem[INDEX_W'(IDX_ASEC)],  calTime[7:0])
                  & fieldHit(mem[INDEX_W'(IDX_AMIN)],  calTime[15:8])
                  & fieldHit(mem[INDEX_W'(IDX_AHOUR)], calTime[23:16]);

  for (genvar k = 0; k < NUM_TIME_FIELDS; k++) begin : gLoadData
    assign calLoadData[8*k +: 8] = mem[timeSlot(k)];
  end

  always_comb begin
    cNext = mem[CI];
    if (dataRd && idx == CI) cNext = '0;
    if (updStb.endUpd) begin
      if (mem[BI][5] && alarmHit) cNext = cNext | 8'hA0;
      if (mem[BI][4])             cNext = cNext | 8'h90;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx     <= '0;
      calLoad <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      mem[AI] <= RST_CTLA;
      mem[BI] <= RST_CTLB;
      mem[DI] <= RST_CTLD;
    end else begin
      calLoad <= 1'b0;
      if (hostWr && !hostSel) idx <= hostWdata[INDEX_W-1:0];

      if (updStb.startUpd && !setMode) mem[AI][7] <= 1'b1;
      if (updStb.endUpd) begin
        if (!setMode)
          for (int k = 0; k < NUM_TIME_FIELDS; k++)
            mem[timeSlot(k)] <= calTime[8*k +: 8];
        mem[AI][7] <= 1'b0;
      end
      mem[CI] <= cNext;

      if (dataWr) begin
        if (idx == AI) begin
          mem[AI][6:0] <= hostWdata[6:0];
        end else if (idx == BI) begin
          mem[BI] <= hostWdata[7] ? (hostWdata & 8'hEF) : hostWdata;
          if (hostWdata[7])  mem[AI][7] <= 1'b0;
          else if (setMode)  calLoad    <= 1'b1;
        end else if (idx == CI || idx == DI) begin
          // read-only control bytes
        end else begin
          mem[idx] <= hostWdata;
          if (isTimeSlot(idx) && !setMode) calLoad <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
  import rtc_reg_pkg::*;
#(
  parameter int INDEX_W   = 7,
  parameter int UIP_TICKS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  input  logic        secTick,
  input  logic        baseTick,
  input  logic [55:0] calTime,
  output logic        calAdvance,
  output logic        calLoad,
  output logic [55:0] calLoadData,
  output logic        irqOut
);
  upd_strobe_t        updStb;
  logic [INDEX_W-1:0] curIndex;
  logic               oscRun;
  logic               uipFlag;
  logic               uieFlag;

  rtc_update_ctrl #(.UIP_TICKS(UIP_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .baseTick(baseTick),
    .oscRun(oscRun), .updStb(updStb)
  );

  rtc_reg_file #(.INDEX_W(INDEX_W)) uRegs (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .updStb(updStb), .calTime(calTime), .calLoad(calLoad),
    .calLoadData(calLoadData), .curIndex(curIndex), .oscRun(oscRun),
    .uipFlag(uipFlag), .uieFlag(uieFlag), .irq(irqOut)
  );

  assign calAdvance = updStb.startUpd;
endmodule

// File: rtl/rtc_host_regs_chk.sv
module rtc_host_regs_chk
  import rtc_reg_pkg::*;
#(
  parameter int INDEX_W = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostSel,
  input logic               hostWr,
  input logic               hostRd,
  input logic [7:0]         hostWdata,
  input logic               calAdvance,
  input logic               irqOut,
  input logic               uipFlag,
  input logic               uieFlag,
  input logic               oscRun,
  input logic [INDEX_W-1:0] curIndex,
  input upd_strobe_t        updStb
);
  localparam logic [INDEX_W-1:0] AI = INDEX_W'(IDX_CTLA);
  localparam logic [INDEX_W-1:0] BI = INDEX_W'(IDX_CTLB);
  localparam logic [INDEX_W-1:0] CI = INDEX_W'(IDX_CTLC);

  AST_INDEX_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostSel) |=> (curIndex == $past(hostWdata[INDEX_W-1:0]))); // R1

  AST_UIP_HOST_PROTECTED: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostSel && curIndex == AI && !updStb.startUpd && !updStb.endUpd)
      |=> (uipFlag == $past(uipFlag))); // R4

  AST_FREEZE_CLEARS_UIE: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostSel && curIndex == BI && hostWdata[7]) |=> (!uieFlag && !uipFlag)); // R5

  AST_UPDATE_END_CLEARS_UIP: assert property (@(posedge clk) disable iff (!rstN)
    updStb.endUpd |=> !uipFlag); // R7

  AST_HALT_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    !oscRun |-> !calAdvance); // R8

  AST_IRQ_ONLY_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(updStb.endUpd)); // R9

  AST_READ_C_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostSel && curIndex == CI && !updStb.endUpd) |=> !irqOut); // R11
endmodule

bind rtc_host_regs rtc_host_regs_chk #(.INDEX_W(INDEX_W)) uChk (.*);

// File: tb/rtc_host_regs_test.sv
module rtc_host_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic        secTick = 1'b0, baseTick = 1'b0;
  logic [55:0] calT = '0;
  logic        calAdvance, calLoad, irqOut;
  logic [55:0] calLoadData;
  int          nChecks = 0, nFails = 0, loadCount = 0;

  always #2.5 clk = ~clk;

  rtc_host_regs uut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .secTick(secTick),
    .baseTick(baseTick), .calTime(calT), .calAdvance(calAdvance),
    .calLoad(calLoad), .calLoadData(calLoadData), .irqOut(irqOut)
  );

  // calendar counter model: binary seconds only
  always @(posedge clk) begin
    if (calLoad) begin
      calT <= calLoadData;
      loadCount <= loadCount + 1;
    end else if (calAdvance) begin
      calT[7:0] <= (calT[7:0] >= 8'd59) ? 8'd0 : calT[7:0] + 8'd1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic sel, input logic [7:0] d);
    @(negedge clk); hostSel = sel; hostWr = 1'b1; hostWdata = d;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic busRead(input logic sel, output logic [7:0] d);
    @(negedge clk); hostSel = sel; hostRd = 1'b1; #1 d = hostRdata;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic regWrite(input int i, input logic [7:0] d);
    busWrite(1'b0, 8'(i)); busWrite(1'b1, d);
  endtask

  task automatic regRead(input int i, output logic [7:0] d);
    busWrite(1'b0, 8'(i)); busRead(1'b1, d);
  endtask

  task automatic startTick();
    @(negedge clk); secTick = 1'b1; @(negedge clk); secTick = 1'b0;
  endtask

  task automatic finishWindow();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); baseTick = 1'b1; @(negedge clk); baseTick = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int lc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R3 reset state
    regRead(10, v); check("R3 A", v, 8'h26);
    regRead(11, v); check("R3 B", v, 8'h02);
    regRead(12, v); check("R3 C", v, 8'h00);
    regRead(13, v); check("R3 D", v, 8'h80);
    check("R3 irq", irqOut, 1'b0);

    // R1 index port
    busRead(1'b0, v); check("R1 even read", v, 8'hFF);
    regWrite(14, 8'h3C);
    busWrite(1'b0, 8'h8E); busRead(1'b1, v); check("R1 index bit7 dropped", v, 8'h3C);

    // R2 plain storage sweep
    for (int i = 14; i < 128; i++) regWrite(i, 8'(i) ^ 8'h5A);
    for (int i = 14; i < 128; i++) begin
      regRead(i, v); check("R2 storage", v, 8'(i) ^ 8'h5A);
    end

    // R4 UIP read-only, C and D ignored
    regWrite(10, 8'hA5); regRead(10, v); check("R4 A bit7 protected", v, 8'h25);
    regWrite(10, 8'h26);
    regWrite(12, 8'hFF); regRead(12, v); check("R4 C ignored", v, 8'h00);
    check("R4 irq after C write", irqOut, 1'b0);
    regWrite(13, 8'h00); regRead(13, v); check("R4 D ignored", v, 8'h80);

    // R6 time write with freeze clear loads counter
    lc = loadCount;
    regWrite(0, 8'h10);
    @(negedge clk);
    check("R6 load on sec write", loadCount - lc, 1);
    check("R6 counter seconds", calT[7:0], 8'h10);
    regWrite(2, 8'h20); regWrite(4, 8'h05);
    @(negedge clk);
    check("R6 counter min/hour", calT[23:8], 16'h0520);

    // R7 normal update
    startTick();
    regRead(10, v); check("R7 UIP set mid-window", v[7], 1'b1);
    finishWindow();
    regRead(10, v); check("R7 UIP cleared", v[7], 1'b0);
    regRead(0, v);  check("R7 seconds copied", v, 8'h11);

    // R5 freeze mode
    regWrite(11, 8'h92); regRead(11, v); check("R5 UIE forced off", v, 8'h82);
    lc = loadCount;
    regWrite(0, 8'h33);
    @(negedge clk);
    check("R6 no load while frozen", loadCount - lc, 0);
    startTick();
    regRead(10, v); check("R7 no UIP while frozen", v[7], 1'b0);
    finishWindow();
    regRead(0, v); check("R7 no copy while frozen", v, 8'h33);
    regWrite(11, 8'h02);
    @(negedge clk);
    check("R5 load on freeze exit", loadCount - lc, 1);
    check("R5 loaded seconds", calT[7:0], 8'h33);

    // R9 update-ended interrupt, R11 read clear
    regWrite(11, 8'h12);
    startTick(); finishWindow();
    @(negedge clk);
    check("R9 irq high", irqOut, 1'b1);
    regRead(12, v); check("R9 C flags", v, 8'h90);
    check("R11 irq cleared", irqOut, 1'b0);
    regRead(12, v); check("R11 C cleared", v, 8'h00);

    // R10 alarm sweep: 0 don't-care, 1 exact, 2 miss
    regWrite(11, 8'h22);
    for (int c = 0; c < 27; c++) begin
      logic [7:0] nxt [3];
      logic [7:0] al;
      logic hit;
      nxt[0] = (calT[7:0] >= 8'd59) ? 8'd0 : calT[7:0] + 8'd1;
      nxt[1] = calT[15:8];
      nxt[2] = calT[23:16];
      hit = 1'b1;
      for (int f = 0; f < 3; f++) begin
        int ch;
        ch = (c / ((f == 0) ? 1 : (f == 1) ? 3 : 9)) % 3;
        if (ch == 0)      al = (c % 2 == 0) ? 8'hC0 : 8'hFF;
        else if (ch == 1) al = nxt[f];
        else begin        al = nxt[f] ^ 8'h01; hit = 1'b0; end
        regWrite(2 * f + 1, al);
      end
      startTick(); finishWindow();
      regRead(12, v); check("R10 alarm flags", v, hit ? 8'hA0 : 8'h00);
    end

    // R8 halted divider
    regWrite(11, 8'h12);
    regWrite(10, 8'h06);
    lc = calT[7:0];
    startTick();
    regRead(10, v); check("R8 no UIP when halted", v, 8'h06);
    finishWindow();
    check("R8 counter not advanced", calT[7:0], 8'(lc));
    regRead(12, v); check("R8 no update flag", v, 8'h00);
    regWrite(10, 8'h26);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule